// File: doc/BRIEF.md
# Memory Traffic Statistics Counter

This block watches a burst-capable, memory-mapped bus and keeps traffic statistics without driving any of the bus signals. It counts accepted read requests, accepted write requests, accepted write beats, the read words asked for through the burst count of each read request, and the read words actually returned. For reads, for writes, and for both kinds of traffic together, it also records how many clock ticks separate the first activity from the most recent one. Software can divide word counts by these spans to get throughput.

Every statistic can be read through a small register port. A register read answers one cycle later with a one-cycle valid pulse. A write to the control address zeroes every statistic and re-arms the first-activity detectors. Every counter saturates at its top value instead of wrapping.

Top module: `mem_traffic_stats`

## Requirements
- R1: After reset every statistic reads as zero and `reg_rvalid` is low.
- R2: The read request counter (address 1) grows by one in each cycle where `bus_read` and `bus_ready` are both high. A read held without ready adds nothing.
- R3: A write beat is accepted when `bus_write` and `bus_ready` are both high. Every accepted beat adds one to the write word counter (address 3). The first beat of a burst adds one to the write request counter (address 2). The next `bus_burst`-1 accepted beats add no request. A burst count of 0 counts as a burst of one beat.
- R4: The requested read word counter (address 4) grows by the value of `bus_burst` on each accepted read request.
- R5: The received read word counter (address 5) grows by one in every cycle with `bus_rvalid` high, whether or not a request is outstanding.
- R6: The read span (address 6) holds the number of cycles from the first read activity to the latest one. Read activity is an accepted read request or a `bus_rvalid` cycle. The span is 0 until a second activity occurs.
- R7: The write span (address 7) does the same for accepted write beats.
- R8: The combined span (address 8) does the same for any read or write activity.
- R9: Every counter and span stops at 2^CNT_W-1 and stays there while activity continues.
- R10: A register write to address 0 zeroes all statistics and re-arms all three first-activity detectors. It wins over activity in the same cycle and does not disturb the write burst tracking. A register write to any other address changes nothing.
- R11: A read request with `reg_rd` high at a clock edge is answered by `reg_rvalid` high with `reg_rdata` after that edge. The data is the value the statistic held before the edge's own update. `reg_rvalid` is low in all other cycles. Address 0 and addresses above 8 read as zero. `reg_ardy` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the monitored bus |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ready | input | 1 | Bus ready; qualifies read and write strobes |
| bus_read | input | 1 | Bus read request strobe |
| bus_write | input | 1 | Bus write beat strobe |
| bus_burst | input | BURST_W | Bus burst length in words |
| bus_rvalid | input | 1 | Returned read data valid |
| reg_addr | input | REG_AW | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_ardy | output | 1 | Register port ready, always high |
| reg_rdata | output | CNT_W | Register read data |
| reg_rvalid | output | 1 | Register read data valid pulse |

## Verification
A wrong burst-tracking state shows up as a wrong write request count at the next read of address 2 after the affected beat. A stuck first-activity flag or a bad elapsed-time counter shows up in the span registers, and the error stays there until the next clear. The bench reads one register every cycle, cycling through all addresses. A wrong value therefore reaches `reg_rdata` within ten cycles of the cause and is compared against the reference model in the same cycle.

// File: rtl/mts_pkg.sv
// Shared definitions for the memory traffic statistics counter.
// Assumes register addresses are word addresses at least 4 bits wide.
package mts_pkg;
    localparam int NUM_CNT  = 5;
    localparam int NUM_SPAN = 3;

    typedef enum logic [3:0] {
        ADR_CTRL     = 4'd0,
        ADR_RD_REQ   = 4'd1,
        ADR_WR_REQ   = 4'd2,
        ADR_WR_WORDS = 4'd3,
        ADR_RD_ASKED = 4'd4,
        ADR_RD_RECV  = 4'd5,
        ADR_RD_SPAN  = 4'd6,
        ADR_WR_SPAN  = 4'd7,
        ADR_ANY_SPAN = 4'd8
    } mts_addr_e;

    // Counter slot indices
    localparam int C_RD_REQ   = 0;
    localparam int C_WR_REQ   = 1;
    localparam int C_WR_WORDS = 2;
    localparam int C_RD_ASKED = 3;
    localparam int C_RD_RECV  = 4;

    // Span slot indices
    localparam int S_RD  = 0;
    localparam int S_WR  = 1;
    localparam int S_ANY = 2;
endpackage

// File: rtl/mts_sat_counter.sv
// Saturating accumulator: adds an unsigned increment every cycle and stops at
// the largest W-bit value. A clear wins over the increment.
// Assumes the increment is zero in idle cycles.
module mts_sat_counter #(
    parameter int W     = 32,
    parameter int INC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     count
);
    localparam int SW = ((W > INC_W) ? W : INC_W) + 1;
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [SW-1:0] sum;
    logic [W-1:0]  nxt;

    // Widened sum and clamp to the top value
    always_comb begin
        sum = SW'(count) + SW'(inc);
        nxt = (sum > SW'(MAXV)) ? MAXV : sum[W-1:0];
    end

    // Count register with clear
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else          count <= nxt;
    end

    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count >= $past(count)));
    a_r9_stays_max: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAXV && !clr) |=> (count == MAXV));
    a_r10_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/mts_span_timer.sv
// First-to-last activity timer. The first activity arms it. After that an
// elapsed tick count runs, and each later activity copies it into the span.
// Both values saturate. A clear disarms the timer.
module mts_span_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         act,
    output logic [W-1:0] span
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic         seen;
    logic [W-1:0] elapsed;

    // Arm on first activity, then track elapsed ticks and latest span
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen    <= 1'b0;
            elapsed <= '0;
            span    <= '0;
        end else if (seen) begin
            if (elapsed != MAXV) elapsed <= elapsed + 1'b1;
            if (act)             span    <= elapsed;
        end else if (act) begin
            seen    <= 1'b1;
            elapsed <= W'(1);
            span    <= '0;
        end
    end

    a_r6_span_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (span <= elapsed));
    a_r10_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!seen && span == '0));
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !clr) |=> $stable(span));
endmodule

// File: rtl/mts_write_tracker.sv
// Write burst tracker: marks the first accepted beat of each burst as a new
// request and counts down the beats that remain. It ignores register clears.
// Assumes the burst count is valid on the first beat of a burst.
module mts_write_tracker #(
    parameter int BURST_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               beat,
    input  logic [BURST_W-1:0] burst,
    output logic               new_req
);
    logic [BURST_W-1:0] remain;

    assign new_req = beat && (remain == '0);

    // Load remaining beats on a new burst, count down on continuation beats
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (beat) begin
            if (remain == '0) remain <= (burst == '0) ? '0 : burst - 1'b1;
            else              remain <= remain - 1'b1;
        end
    end

    a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && remain != '0) |=> (remain == $past(remain) - 1'b1));
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !beat |=> $stable(remain));
endmodule

// File: rtl/mem_traffic_stats.sv
// Memory traffic statistics counter. It passively observes a burst-capable
// memory bus, keeps saturating request, word and span statistics, and serves
// them through a register port with one-cycle read latency. Assumes the bus
// and the register port share clk.
module mem_traffic_stats
    import mts_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int BURST_W = 7,
    parameter int REG_AW  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_ready,
    input  logic               bus_read,
    input  logic               bus_write,
    input  logic [BURST_W-1:0] bus_burst,
    input  logic               bus_rvalid,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    output logic               reg_ardy,
    output logic [CNT_W-1:0]   reg_rdata,
    output logic               reg_rvalid
);
    logic               rd_acc, wr_acc, wr_new, clr;
    logic [BURST_W-1:0] ev_inc [NUM_CNT];
    logic               sp_act [NUM_SPAN];
    logic [CNT_W-1:0]   cnt    [NUM_CNT];
    logic [CNT_W-1:0]   span   [NUM_SPAN];
    logic [CNT_W-1:0]   rd_mux;

    assign reg_ardy = 1'b1;

    // Decode accepted bus events and the clear command
    always_comb begin
        rd_acc = bus_read && bus_ready;
        wr_acc = bus_write && bus_ready;
        clr    = reg_wr && (reg_addr == REG_AW'(ADR_CTRL));
    end

    mts_write_tracker #(.BURST_W(BURST_W)) u_wtrk (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat    (wr_acc),
        .burst   (bus_burst),
        .new_req (wr_new)
    );

    // Per-counter increments and per-span activity
    always_comb begin
        ev_inc[C_RD_REQ]   = BURST_W'(rd_acc);
        ev_inc[C_WR_REQ]   = BURST_W'(wr_new);
        ev_inc[C_WR_WORDS] = BURST_W'(wr_acc);
        ev_inc[C_RD_ASKED] = rd_acc ? bus_burst : '0;
        ev_inc[C_RD_RECV]  = BURST_W'(bus_rvalid);
        sp_act[S_RD]       = rd_acc || bus_rvalid;
        sp_act[S_WR]       = wr_acc;
        sp_act[S_ANY]      = rd_acc || bus_rvalid || wr_acc;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
            mts_sat_counter #(.W(CNT_W), .INC_W(BURST_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr),
                .inc   (ev_inc[gi]),
                .count (cnt[gi])
            );
        end
        for (gi = 0; gi < NUM_SPAN; gi++) begin : g_span
            mts_span_timer #(.W(CNT_W)) u_span (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr),
                .act   (sp_act[gi]),
                .span  (span[gi])
            );
        end
    endgenerate

    // Register read selection
    always_comb begin
        rd_mux = '0;
        if (reg_addr == REG_AW'(ADR_RD_REQ))   rd_mux = cnt[C_RD_REQ];
        if (reg_addr == REG_AW'(ADR_WR_REQ))   rd_mux = cnt[C_WR_REQ];
        if (reg_addr == REG_AW'(ADR_WR_WORDS)) rd_mux = cnt[C_WR_WORDS];
        if (reg_addr == REG_AW'(ADR_RD_ASKED)) rd_mux = cnt[C_RD_ASKED];
        if (reg_addr == REG_AW'(ADR_RD_RECV))  rd_mux = cnt[C_RD_RECV];
        if (reg_addr == REG_AW'(ADR_RD_SPAN))  rd_mux = span[S_RD];
        if (reg_addr == REG_AW'(ADR_WR_SPAN))  rd_mux = span[S_WR];
        if (reg_addr == REG_AW'(ADR_ANY_SPAN)) rd_mux = span[S_ANY];
    end

    // Registered read response, one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_rd;
            reg_rdata  <= reg_rd ? rd_mux : '0;
        end
    end

    a_r11_answer: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);
    a_r2_held_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read && !bus_ready && !clr) |=> $stable(cnt[C_RD_REQ]));
endmodule

// File: tb/sim_mem_traffic_stats.sv
module sim_mem_traffic_stats;
    localparam int CW   = 8;
    localparam int MAXV = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_ready = 0, bus_read = 0, bus_write = 0, bus_rvalid = 0;
    logic [6:0] bus_burst = '0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 0, reg_rd = 0;
    logic       reg_ardy, reg_rvalid;
    logic [CW-1:0] reg_rdata;

    int checks = 0, errors = 0;
    bit finished = 0;

    // reference model state
    int m_cnt [5];
    int m_seen [3], m_el [3], m_sp [3];
    int m_rem = 0;
    bit pend = 0;
    int pend_val = 0;
    string pend_tag = "";
    string phase_tag = "";

    mem_traffic_stats #(.CNT_W(CW), .BURST_W(7), .REG_AW(4)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready), .bus_read(bus_read),
        .bus_write(bus_write), .bus_burst(bus_burst), .bus_rvalid(bus_rvalid),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_ardy(reg_ardy), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int sat(input int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            1: return "R2";
            2: return "R3";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R11";
        endcase
    endfunction

    function automatic int model_read(input int a);
        if (a >= 1 && a <= 5) return m_cnt[a-1];
        if (a >= 6 && a <= 8) return m_sp[a-6];
        return 0;
    endfunction

    // one bus cycle: check last answer, drive, advance model
    task automatic step(input bit rd, input bit wr, input bit rdy, input bit rv,
                        input int burst, input int ra, input bit rw, input bit rr);
        bit clr, racc, wacc, wnew;
        bit act [3];
        @(negedge clk);
        chk("R11", int'(reg_rvalid), int'(pend));
        if (pend) chk(pend_tag, int'(reg_rdata), pend_val);
        bus_read = rd; bus_write = wr; bus_ready = rdy; bus_rvalid = rv;
        bus_burst = 7'(burst); reg_addr = 4'(ra); reg_wr = rw; reg_rd = rr;
        pend = rr;
        if (rr) begin
            pend_val = model_read(ra);
            pend_tag = (phase_tag != "") ? phase_tag : tag_of(ra);
        end
        clr  = rw && (ra == 0);
        racc = rd && rdy;
        wacc = wr && rdy;
        wnew = 0;
        if (wacc) begin
            if (m_rem == 0) begin
                wnew = 1;
                m_rem = (burst == 0) ? 0 : burst - 1;
            end else m_rem--;
        end
        act[0] = racc || rv; act[1] = wacc; act[2] = racc || rv || wacc;
        if (clr) begin
            foreach (m_cnt[i]) m_cnt[i] = 0;
            for (int i = 0; i < 3; i++) begin m_seen[i] = 0; m_el[i] = 0; m_sp[i] = 0; end
        end else begin
            m_cnt[0] = sat(m_cnt[0] + int'(racc));
            m_cnt[1] = sat(m_cnt[1] + int'(wnew));
            m_cnt[2] = sat(m_cnt[2] + int'(wacc));
            m_cnt[3] = sat(m_cnt[3] + (racc ? burst : 0));
            m_cnt[4] = sat(m_cnt[4] + int'(rv));
            for (int i = 0; i < 3; i++) begin
                if (m_seen[i] != 0) begin
                    if (act[i]) m_sp[i] = m_el[i];
                    m_el[i] = sat(m_el[i] + 1);
                end else if (act[i]) begin
                    m_seen[i] = 1; m_el[i] = 1; m_sp[i] = 0;
                end
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        foreach (m_cnt[i]) m_cnt[i] = 0;
        for (int i = 0; i < 3; i++) begin m_seen[i] = 0; m_el[i] = 0; m_sp[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, all registers zero
        chk("R1", int'(reg_rvalid), 0);
        chk("R11", int'(reg_ardy), 1);
        phase_tag = "R1";
        for (int a = 0; a < 10; a++) step(0, 0, 1, 0, 0, a, 0, 1);
        phase_tag = "";
        // R2: held read without ready, then accepted read burst 3
        step(1, 0, 0, 0, 3, 1, 0, 0);
        step(1, 0, 1, 0, 3, 1, 0, 1);
        step(0, 0, 1, 0, 0, 1, 0, 1);
        step(0, 0, 1, 0, 0, 4, 0, 1);
        // R3: write burst of 4 with a stall, then burst 0
        step(0, 1, 1, 0, 4, 2, 0, 1);
        step(0, 1, 0, 0, 4, 3, 0, 1);
        for (int k = 0; k < 3; k++) step(0, 1, 1, 0, 4, 2, 0, 1);
        step(0, 1, 1, 0, 0, 2, 0, 1);
        step(0, 1, 1, 0, 0, 3, 0, 1);
        // R5/R6/R8: unsolicited returned data, spans
        step(0, 0, 1, 1, 0, 5, 0, 1);
        for (int a = 5; a < 10; a++) step(0, 0, 1, 0, 0, a, 0, 1);
        // R10: non-control write ignored, then clear during activity
        step(1, 1, 1, 1, 2, 3, 1, 1);
        step(0, 0, 1, 0, 0, 3, 0, 1);
        step(1, 1, 1, 1, 2, 0, 1, 1);
        phase_tag = "R10";
        for (int a = 0; a < 10; a++) step(0, 0, 1, 0, 0, a, 0, 1);
        phase_tag = "";
        // random traffic with rotating reads
        for (int c = 0; c < 4000; c++) begin
            step(($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 4) != 0,
                 ($urandom % 3) == 0, int'($urandom % 5), c % 10,
                 ($urandom % 40) == 0, 1);
        end
        // R9: drive everything past saturation
        step(0, 0, 1, 0, 0, 0, 1, 0);
        for (int c = 0; c < 400; c++) step(1, 1, 1, 1, 7, 0, 0, 0);
        phase_tag = "R9";
        for (int c = 0; c < 10; c++) step(1, 1, 1, 1, 7, c, 0, 1);
        for (int c = 0; c < 10; c++) step(0, 0, 1, 0, 0, c, 0, 1);
        phase_tag = "";
        step(0, 0, 1, 0, 0, 0, 0, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule